// File: doc/BRIEF.md
# Deserializer Output Mode Controller

This block sits at the parallel side of a video deserializer. It decides which recovered word stream reaches the output bus and what the lock indicator shows. Three strap inputs pick the route. A master/slave strap, a standard-stream strap and an ASI strap are sampled every parallel clock.

When all three straps are low the block works as a plain serial-to-parallel converter. The raw, unaligned words pass straight through with no decoding, descrambling or word alignment. In that case the lock indicator follows the analog PLL lock alone, so streams that do not conform to any standard can still be reclocked.

In master mode the block watches for timing reference (TRS) words itself. If a programmable number of consecutive words passes with no TRS, it drives its standard-stream output low. While that output is low, the data bus and the lock indicator are held at zero. Any TRS detection restores normal decoded output.

In slave mode with the standard or ASI strap high, the decoded stream and the decoder's lock are passed on. The standard-stream output echoes the strap.

Top module: `deser_mode_ctrl`

## Requirements
- R1: When strap_master_i, strap_std_i and strap_asi_i are all 0 at a clock edge, data_o after that edge equals raw_word_i sampled at that edge.
- R2: In the all-straps-low route, lock_o after an edge equals pll_lock_i sampled at that edge, and std_o is 0.
- R3: In master mode, after MISS_LIMIT consecutive clock edges with trs_seen_i low, the missing-TRS condition is set. From the next edge on, std_o is 0.
- R4: In master mode, while the missing-TRS condition holds, every bit of data_o and lock_o is 0 after each edge.
- R5: A clock edge with trs_seen_i high clears the missing-TRS condition. In master mode, std_o is 1 after the following edge.
- R6: In master mode without the missing-TRS condition, data_o equals dec_word_i, lock_o equals dec_lock_i, and std_o is 1, each as sampled one edge earlier.
- R7: With strap_master_i at 0 and strap_std_i or strap_asi_i at 1, data_o equals dec_word_i, lock_o equals dec_lock_i, and std_o equals strap_std_i, each as sampled one edge earlier.
- R8: A clock edge with rst high sets data_o, lock_o and std_o to 0. It also sets the missing-TRS condition, so master mode stays blanked until a TRS is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_master_i | input | 1 | 1 = master mode (block owns the standard-stream decision) |
| strap_std_i | input | 1 | Standard-stream strap, used in slave mode |
| strap_asi_i | input | 1 | ASI stream strap |
| pll_lock_i | input | 1 | Analog PLL lock flag |
| dec_lock_i | input | 1 | Lock flag from the decode path |
| trs_seen_i | input | 1 | High for a word in which a TRS was detected |
| dec_word_i | input | W | Word from the decode path |
| raw_word_i | input | W | Raw deserialized word |
| data_o | output | W | Registered output data bus |
| lock_o | output | 1 | Registered lock indicator |
| std_o | output | 1 | Registered standard-stream signal (low = bypass) |

## Verification
The main function is tried with three strap patterns, each fed with random word streams. All straps low must show the raw words and PLL lock. The slave patterns must show the decoded words and decoder lock, which tells the two data paths and the two lock sources apart. Master mode is driven with frequent random TRS pulses and then with a TRS-free gap longer than the limit. This shows the exact edge where blanking begins and the two-edge release after a TRS. A reset in the middle of master traffic confirms that blanking resumes until the next TRS.

// File: rtl/dsom_pkg.sv
package dsom_pkg;
  typedef enum logic [1:0] {
    ROUTE_RAW    = 2'd0,
    ROUTE_MASTER = 2'd1,
    ROUTE_SLAVE  = 2'd2
  } route_e;
endpackage

// File: rtl/dsom_route_sel.sv
module dsom_route_sel
  import dsom_pkg::*;
(
  input  logic   master_i,
  input  logic   std_i,
  input  logic   asi_i,
  output route_e route_o
);
  always_comb begin
    if (master_i)            route_o = ROUTE_MASTER;
    else if (std_i || asi_i) route_o = ROUTE_SLAVE;
    else                     route_o = ROUTE_RAW;
  end
endmodule

// File: rtl/dsom_trs_watch.sv
module dsom_trs_watch #(
  parameter int MISS_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic trs_i,
  output logic missing_o
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      missing_o <= 1'b1;
    end else if (trs_i) begin
      gap_q     <= '0;
      missing_o <= 1'b0;
    end else if (!missing_o) begin
      if (gap_q == LAST) missing_o <= 1'b1;
      else               gap_q     <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsom_out_stage.sv
module dsom_out_stage
  import dsom_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  route_e       route_i,
  input  logic         missing_i,
  input  logic         std_strap_i,
  input  logic         pll_lock_i,
  input  logic         dec_lock_i,
  input  logic [W-1:0] dec_word_i,
  input  logic [W-1:0] raw_word_i,
  output logic [W-1:0] data_o,
  output logic         lock_o,
  output logic         std_o
);
  logic [W-1:0] data_d;
  logic         lock_d;
  logic         std_d;

  always_comb begin
    data_d = dec_word_i;
    lock_d = dec_lock_i;
    std_d  = 1'b1;
    unique case (route_i)
      ROUTE_RAW: begin
        data_d = raw_word_i;
        lock_d = pll_lock_i;
        std_d  = 1'b0;
      end
      ROUTE_MASTER: begin
        if (missing_i) begin
          data_d = '0;
          lock_d = 1'b0;
          std_d  = 1'b0;
        end
      end
      default: std_d = std_strap_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      lock_o <= 1'b0;
      std_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      lock_o <= lock_d;
      std_o  <= std_d;
    end
  end
endmodule

// File: rtl/deser_mode_ctrl.sv
module deser_mode_ctrl
  import dsom_pkg::*;
#(
  parameter int W          = 20,
  parameter int MISS_LIMIT = 4096
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strap_master_i,
  input  logic         strap_std_i,
  input  logic         strap_asi_i,
  input  logic         pll_lock_i,
  input  logic         dec_lock_i,
  input  logic         trs_seen_i,
  input  logic [W-1:0] dec_word_i,
  input  logic [W-1:0] raw_word_i,
  output logic [W-1:0] data_o,
  output logic         lock_o,
  output logic         std_o
);
  route_e route;
  logic   missing;

  dsom_route_sel i_sel (
    .master_i (strap_master_i),
    .std_i    (strap_std_i),
    .asi_i    (strap_asi_i),
    .route_o  (route)
  );

  dsom_trs_watch #(.MISS_LIMIT(MISS_LIMIT)) i_watch (
    .clk       (clk),
    .rst       (rst),
    .trs_i     (trs_seen_i),
    .missing_o (missing)
  );

  dsom_out_stage #(.W(W)) i_out (
    .clk         (clk),
    .rst         (rst),
    .route_i     (route),
    .missing_i   (missing),
    .std_strap_i (strap_std_i),
    .pll_lock_i  (pll_lock_i),
    .dec_lock_i  (dec_lock_i),
    .dec_word_i  (dec_word_i),
    .raw_word_i  (raw_word_i),
    .data_o      (data_o),
    .lock_o      (lock_o),
    .std_o       (std_o)
  );
endmodule

// File: rtl/deser_mode_ctrl_chk.sv
module deser_mode_ctrl_chk #(
  parameter int W          = 20,
  parameter int MISS_LIMIT = 4096
) (
  input logic         clk,
  input logic         rst,
  input logic         strap_master_i,
  input logic         strap_std_i,
  input logic         strap_asi_i,
  input logic         pll_lock_i,
  input logic         dec_lock_i,
  input logic         trs_seen_i,
  input logic [W-1:0] dec_word_i,
  input logic [W-1:0] raw_word_i,
  input logic [W-1:0] data_o,
  input logic         lock_o,
  input logic         std_o
);
  int unsigned quiet_q;
  always_ff @(posedge clk) begin
    if (rst || trs_seen_i)              quiet_q <= 0;
    else if (quiet_q <= MISS_LIMIT + 1) quiet_q <= quiet_q + 1;
  end

  logic raw_route, slave_route;
  assign raw_route   = !strap_master_i && !strap_std_i && !strap_asi_i;
  assign slave_route = !strap_master_i && (strap_std_i || strap_asi_i);

  assert_raw_data_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(raw_route)) |-> data_o == $past(raw_word_i));

  assert_raw_lock_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(raw_route)) |-> (lock_o == $past(pll_lock_i) && !std_o));

  assert_miss_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && quiet_q > MISS_LIMIT && $past(strap_master_i)) |-> !std_o);

  assert_blank_outputs_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strap_master_i) && !std_o) |-> (data_o == '0 && !lock_o));

  assert_trs_release_R5: assert property (@(posedge clk) disable iff (rst)
    (trs_seen_i ##1 strap_master_i) |=> std_o);

  assert_slave_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(slave_route)) |->
      (data_o == $past(dec_word_i) && lock_o == $past(dec_lock_i) && std_o == $past(strap_std_i)));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (data_o == '0 && !lock_o && !std_o));
endmodule

bind deser_mode_ctrl deser_mode_ctrl_chk #(.W(W), .MISS_LIMIT(MISS_LIMIT)) i_chk (
  .clk(clk), .rst(rst), .strap_master_i(strap_master_i), .strap_std_i(strap_std_i),
  .strap_asi_i(strap_asi_i), .pll_lock_i(pll_lock_i), .dec_lock_i(dec_lock_i),
  .trs_seen_i(trs_seen_i), .dec_word_i(dec_word_i), .raw_word_i(raw_word_i),
  .data_o(data_o), .lock_o(lock_o), .std_o(std_o)
);

// File: tb/test_deser_mode_ctrl.sv
`timescale 1ns/1ps
module test_deser_mode_ctrl;
  localparam int W     = 20;
  localparam int LIMIT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m = 1'b0, s = 1'b0, a = 1'b0, pll = 1'b0, dl = 1'b0, trs = 1'b0;
  logic [W-1:0] dw = '0, rw = '0;
  logic [W-1:0] data_o;
  logic lock_o, std_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  deser_mode_ctrl #(.W(W), .MISS_LIMIT(LIMIT)) i_deser_mode_ctrl (
    .clk(clk), .rst(rst), .strap_master_i(m), .strap_std_i(s), .strap_asi_i(a),
    .pll_lock_i(pll), .dec_lock_i(dl), .trs_seen_i(trs), .dec_word_i(dw),
    .raw_word_i(rw), .data_o(data_o), .lock_o(lock_o), .std_o(std_o)
  );

  // behavioural reference
  logic [W-1:0] e_data;
  logic e_lock, e_std;
  bit   miss = 1'b1;
  int   gap = 0;
  bit   primed = 1'b0;
  string t_data, t_lock, t_std;

  always @(posedge clk) begin
    primed = 1'b1;
    if (rst) begin
      e_data = '0; e_lock = 1'b0; e_std = 1'b0;
      miss = 1'b1; gap = 0;
      t_data = "R8"; t_lock = "R8"; t_std = "R8";
    end else begin
      if (!m && !s && !a) begin
        e_data = rw; e_lock = pll; e_std = 1'b0;
        t_data = "R1"; t_lock = "R2"; t_std = "R2";
      end else if (m) begin
        if (miss) begin
          e_data = '0; e_lock = 1'b0; e_std = 1'b0;
          t_data = "R4"; t_lock = "R4"; t_std = "R3";
        end else begin
          e_data = dw; e_lock = dl; e_std = 1'b1;
          t_data = "R6"; t_lock = "R6"; t_std = "R5";
        end
      end else begin
        e_data = dw; e_lock = dl; e_std = s;
        t_data = "R7"; t_lock = "R7"; t_std = "R7";
      end
      if (trs) begin
        miss = 1'b0; gap = 0;
      end else if (!miss) begin
        gap++;
        if (gap >= LIMIT) miss = 1'b1;
      end
    end
  end

  task automatic compare();
    if (!primed) return;
    checks++;
    if (data_o !== e_data) begin
      errors++;
      $display("FAIL %s data_o actual %h expected %h", t_data, data_o, e_data);
    end
    checks++;
    if (lock_o !== e_lock) begin
      errors++;
      $display("FAIL %s lock_o actual %b expected %b", t_lock, lock_o, e_lock);
    end
    checks++;
    if (std_o !== e_std) begin
      errors++;
      $display("FAIL %s std_o actual %b expected %b", t_std, std_o, e_std);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      dw  = W'($urandom);
      rw  = W'($urandom);
      pll = 1'($urandom);
      dl  = 1'($urandom);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    cyc(4);
    rst = 1'b0;
    // R1, R2: raw route with all straps low
    cyc(40);
    // R8: master blanked after reset until a TRS; R4 blank outputs
    m = 1'b1;
    cyc(20);
    // R5, R6: TRS releases, then random TRS traffic keeps stream normal
    trs = 1'b1; cyc(1); trs = 1'b0;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      trs = ($urandom % 4) == 0;
    end
    trs = 1'b0;
    // R3, R4: gap longer than the limit
    cyc(LIMIT + 8);
    // R5: single TRS then normal again
    trs = 1'b1; cyc(1); trs = 1'b0;
    cyc(LIMIT - 2);
    trs = 1'b1; cyc(1); trs = 1'b0;
    cyc(LIMIT + 4);
    // R7: slave routes
    m = 1'b0; s = 1'b1; a = 1'b0; cyc(20);
    s = 1'b0; a = 1'b1; cyc(20);
    s = 1'b1; a = 1'b1; cyc(10);
    // R8: reset mid master traffic, blank until next TRS
    m = 1'b1; trs = 1'b1; cyc(3); trs = 1'b0;
    rst = 1'b1; cyc(2); rst = 1'b0;
    cyc(10);
    trs = 1'b1; cyc(1); trs = 1'b0;
    cyc(10);
    // back to raw route
    m = 1'b0; s = 1'b0; a = 1'b0; cyc(20);
    cyc(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule